// File: doc/BRIEF.md
# MDIO Management Master

This block drives a two-wire PHY management bus (MDC clock, bidirectional MDIO data) from a small 32-bit register interface. Software sets the framing style once through a configuration bit. It can use the short-address format (start code 01) or the extended, device-addressed format (start code 00). Software then launches transactions by writing registers. No separate go bit exists. Writing the control register with its read bit set starts a read. Writing the data register starts a write that uses the port and register/device fields already latched in control. In extended mode, writing the address register starts an address frame.

Every frame is sent MSB first. It opens with a run of ones (the preamble), then the start code, opcode, port address, register or device address, a two-bit turnaround and a 16-bit payload. On reads the master releases MDIO from the first turnaround bit onward. It checks that the PHY pulls the second turnaround bit low, and shifts the 16 returned bits into the data register. One offset serves both purposes: writes to it set the configuration, and reads from it return status. The status holds a busy flag, the configuration bit and a read-error flag. Software polls busy and discards read data when the error flag is set.

Top module: `mdio_master`

## Requirements
- R1: After reset the status word (offset 0x30) and the data word (offset 0x38) read 0, MDC is low and MDIO is released (mdio_oe low).
- R2: Writing offset 0x30 sets extended framing when bit 6 is 1 and short framing when it is 0; a read of offset 0x30 returns that setting in bit 6.
- R3: A write to offset 0x34 latches the port address from bits [9:5] and the register/device number from bits [4:0], readable at the same offset; with bit 15 clear it starts no frame.
- R4: A write to offset 0x38 starts a write frame carrying wdata[15:0]: start code 01 and opcode 01 in short mode, start code 00 and opcode 01 in extended mode, turnaround driven as 1 then 0.
- R5: A write to offset 0x3C stores a 16-bit register address (readable there). In extended mode it also starts an address frame with start code 00, opcode 00 and that address as payload. In short mode it starts nothing.
- R6: A write to offset 0x34 with bit 15 set starts a read frame with opcode 10 (short) or 11 (extended). The master never drives MDIO from the first turnaround bit to the frame end, and the 16 sampled bits appear in bits [15:0] of offset 0x38.
- R7: Status bit 1 is set when the second turnaround bit of a read is sampled as 1, and is cleared when the next frame starts.
- R8: Each frame begins with PRE_LEN ones driven by the master, followed by start code, opcode, 5-bit port, 5-bit register/device, 2-bit turnaround and 16-bit payload, each MSB first.
- R9: Status bit 31 (busy) is set at the clock edge that accepts a frame-starting write and clears at the MDC falling edge that ends the last frame bit.
- R10: While busy, writes to offsets 0x34, 0x38 and 0x3C are discarded: no frame starts and no latched field changes.
- R11: MDC has a period of CLK_DIV system clocks with equal high and low halves while a frame runs and stays low when idle. MDIO changes only at MDC falling edges and is sampled at rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; reg_rdata valid the next cycle |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO drive enable (low = released) |
| mdio_i | input | 1 | MDIO value seen on the line |

## Verification
The bench builds the block with CLK_DIV=4, PRE_LEN=32 and ADDR_W=8. The small divisor keeps each 64-bit frame near 256 clocks, so one run covers frames in both framing modes, a read with an answering PHY model, a read with a silent one, and a burst of writes sent while a frame runs. The divisor of 4 also makes the MDC period and duty easy to measure in whole clocks. The full 32-bit preamble is kept so that the captured frame words match the complete frame format.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_W = 32;

  localparam logic [7:0] OFF_CFG  = 8'h30;
  localparam logic [7:0] OFF_CTL  = 8'h34;
  localparam logic [7:0] OFF_DATA = 8'h38;
  localparam logic [7:0] OFF_ADDR = 8'h3C;

  localparam int CFG_EXT_BIT  = 6;
  localparam int STAT_BSY_BIT = 31;
  localparam int STAT_ERR_BIT = 1;
  localparam int CTL_RD_BIT   = 15;

  localparam logic [1:0] OPC_ADDR = 2'b00;
  localparam logic [1:0] OPC_WR   = 2'b01;
  localparam logic [1:0] OPC_RDS  = 2'b10;
  localparam logic [1:0] OPC_RDX  = 2'b11;

  typedef struct packed {
    logic [1:0]  st;
    logic [1:0]  op;
    logic [4:0]  port;
    logic [4:0]  dev;
    logic [1:0]  ta;
    logic [15:0] payload;
  } mdio_hdr_t;

  function automatic mdio_hdr_t make_hdr(input logic ext, input logic [1:0] op,
                                         input logic [4:0] port, input logic [4:0] dev,
                                         input logic [15:0] payload);
    mdio_hdr_t h;
    h.st      = ext ? 2'b00 : 2'b01;
    h.op      = op;
    h.port    = port;
    h.dev     = dev;
    h.ta      = 2'b10;
    h.payload = payload;
    return h;
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign rise_stb = run && (cnt == CW'(HALF - 1));
  assign fall_stb = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= fall_stb ? '0 : cnt + CW'(1);
      if (rise_stb)      mdc <= 1'b1;
      else if (fall_stb) mdc <= 1'b0;
    end
  end

  // R11
  mdc_stops_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(run) |-> !mdc);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  mdio_hdr_t   hdr,
  input  logic        is_read,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        rd_err,
  output logic [15:0] rd_data
);
  localparam int BODY  = $bits(mdio_hdr_t);
  localparam int TOT   = PRE_LEN + BODY;
  localparam int CW    = $clog2(TOT + 1);
  localparam int TA_HI = PRE_LEN + 14;
  localparam int TA_LO = PRE_LEN + 15;
  localparam int DAT0  = PRE_LEN + 16;

  logic [CW-1:0]   bit_idx;
  logic [CW-1:0]   nxt_idx;
  logic [BODY-1:0] sh;
  logic            rd_q;
  logic [15:0]     cap;

  assign nxt_idx = bit_idx + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      bit_idx <= '0;
      sh      <= '0;
      rd_q    <= 1'b0;
      rd_err  <= 1'b0;
      cap     <= '0;
      rd_data <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        mdio_oe <= 1'b1;
        mdio_o  <= 1'b1;
        bit_idx <= '0;
        sh      <= hdr;
        rd_q    <= is_read;
        rd_err  <= 1'b0;
      end
    end else begin
      if (rise_stb && rd_q) begin
        if (bit_idx == CW'(TA_LO)) rd_err <= mdio_i;
        if (bit_idx >= CW'(DAT0))  cap <= {cap[14:0], mdio_i};
      end
      if (fall_stb) begin
        if (bit_idx == CW'(TOT - 1)) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b1;
          if (rd_q) rd_data <= cap;
        end else begin
          bit_idx <= nxt_idx;
          if (nxt_idx >= CW'(PRE_LEN)) begin
            mdio_o <= sh[BODY-1];
            sh     <= {sh[BODY-2:0], 1'b0};
          end
          mdio_oe <= !(rd_q && (nxt_idx >= CW'(TA_HI)));
        end
      end
    end
  end

  // R8
  preamble_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && (bit_idx < CW'(PRE_LEN))) |-> (mdio_oe && mdio_o));

  // R11
  mdio_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> $past(fall_stb));

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(fall_stb) && ($past(bit_idx) == CW'(TOT - 1))));
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              busy,
  input  logic              rd_err,
  input  logic [15:0]       rd_data,
  output logic              start,
  output mdio_hdr_t         hdr,
  output logic              is_read
);
  logic        ext_q;
  logic [4:0]  port_q;
  logic [4:0]  dev_q;
  logic [15:0] addr_q;
  logic        sel_cfg, sel_ctl, sel_data, sel_addr;
  logic [REG_W-1:0] stat;
  logic        unused_wbits;

  assign sel_cfg  = (reg_addr == ADDR_W'(OFF_CFG));
  assign sel_ctl  = (reg_addr == ADDR_W'(OFF_CTL));
  assign sel_data = (reg_addr == ADDR_W'(OFF_DATA));
  assign sel_addr = (reg_addr == ADDR_W'(OFF_ADDR));
  assign unused_wbits = ^{reg_wdata[31:16], reg_wdata[14:10]};

  always_comb begin
    start   = 1'b0;
    is_read = 1'b0;
    hdr     = '0;
    if (reg_wr && !busy) begin
      if (sel_ctl && reg_wdata[CTL_RD_BIT]) begin
        start   = 1'b1;
        is_read = 1'b1;
        hdr     = make_hdr(ext_q, ext_q ? OPC_RDX : OPC_RDS,
                           reg_wdata[9:5], reg_wdata[4:0], 16'h0000);
      end else if (sel_data) begin
        start = 1'b1;
        hdr   = make_hdr(ext_q, OPC_WR, port_q, dev_q, reg_wdata[15:0]);
      end else if (sel_addr && ext_q) begin
        start = 1'b1;
        hdr   = make_hdr(1'b1, OPC_ADDR, port_q, dev_q, reg_wdata[15:0]);
      end
    end
  end

  always_comb begin
    stat               = '0;
    stat[STAT_BSY_BIT] = busy;
    stat[CFG_EXT_BIT]  = ext_q;
    stat[STAT_ERR_BIT] = rd_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q     <= 1'b0;
      port_q    <= '0;
      dev_q     <= '0;
      addr_q    <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr) begin
        if (sel_cfg) ext_q <= reg_wdata[CFG_EXT_BIT];
        if (sel_ctl && !busy) begin
          port_q <= reg_wdata[9:5];
          dev_q  <= reg_wdata[4:0];
        end
        if (sel_addr && !busy) addr_q <= reg_wdata[15:0];
      end
      if (reg_rd) begin
        if (sel_cfg)       reg_rdata <= stat;
        else if (sel_ctl)  reg_rdata <= {22'h0, port_q, dev_q};
        else if (sel_data) reg_rdata <= {16'h0, rd_data};
        else if (sel_addr) reg_rdata <= {16'h0, addr_q};
        else               reg_rdata <= '0;
      end
    end
  end

  // R9
  busy_on_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !busy && sel_data) |=> busy);

  // R3
  ctl_no_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !busy && sel_ctl && !reg_wdata[CTL_RD_BIT]) |=> !busy);

  // R10
  busy_ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && busy && sel_ctl) |=> ($stable(port_q) && $stable(dev_q)));

  // R10
  busy_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && busy && sel_addr) |=> $stable(addr_q));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 8,
  parameter int PRE_LEN = 32,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic        busy, rd_err, start, is_read, rise_stb, fall_stb;
  logic [15:0] rd_data;
  mdio_hdr_t   hdr;

  mdio_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .rd_err(rd_err), .rd_data(rd_data),
    .start(start), .hdr(hdr), .is_read(is_read)
  );

  mdio_mdc_gen #(.DIV(CLK_DIV)) u_mdc (
    .clk(clk), .rst(rst), .run(busy),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_eng #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk(clk), .rst(rst), .start(start), .hdr(hdr), .is_read(is_read),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_err(rd_err), .rd_data(rd_data)
  );
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  localparam int DIV = 4;
  localparam int PRE = 32;
  localparam logic [7:0] A_CFG = 8'h30, A_CTL = 8'h34, A_DAT = 8'h38, A_ADR = 8'h3C;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mdc, dut_o, dut_oe, mdio_line;
  logic phy_o = 1'b1, phy_oe = 1'b0;

  always #2 clk = ~clk;

  assign mdio_line = dut_oe ? dut_o : (phy_oe ? phy_o : 1'b1);

  mdio_master #(.CLK_DIV(DIV), .PRE_LEN(PRE), .ADDR_W(8)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mdc(mdc), .mdio_o(dut_o), .mdio_oe(dut_oe), .mdio_i(mdio_line)
  );

  int n_chk = 0, n_bad = 0, clash = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] fr(input logic [1:0] st, input logic [1:0] op, input logic [4:0] p,
                                     input logic [4:0] d, input logic [1:0] ta, input logic [15:0] pl);
    return {32'hFFFF_FFFF, st, op, p, d, ta, pl};
  endfunction

  // PHY model and scoreboard monitor
  int pcnt = 0;
  logic [63:0] pcap = '0;
  bit presp = 0, pmute = 0;
  logic [15:0] pdata = '0;

  always @(posedge mdc) begin
    pcap = {pcap[62:0], mdio_line};
    pcnt = pcnt + 1;
  end

  always @(negedge mdc) begin
    if (pcnt == 47) begin
      presp = !pmute && ((pcap[14:13] == 2'b01 && pcap[12:11] == 2'b10) ||
                         (pcap[14:13] == 2'b00 && pcap[12:11] == 2'b11));
      if (presp) begin phy_oe = 1'b1; phy_o = 1'b0; end
    end else if (pcnt >= 48 && pcnt <= 63) begin
      if (presp) begin phy_oe = 1'b1; phy_o = pdata[63-pcnt]; end
    end else if (pcnt == 64) begin
      phy_oe = 1'b0;
      presp  = 0;
      if (exp_q.size() == 0) check(0, "R10 unexpected frame on bus", pcap, 64'h0);
      else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(pcap == e, t, pcap, e);
      end
      pcnt = 0;
    end
  end

  always @(posedge clk) if (dut_oe && phy_oe) clash++;

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic expect_frame(input logic [63:0] f, input string t);
    exp_q.push_back(f);
    tag_q.push_back(t);
  endtask

  task automatic wait_idle(input string t);
    logic [31:0] s;
    bit done = 0;
    for (int i = 0; i < 2000 && !done; i++) begin
      rd(A_CFG, s);
      if (!s[31]) done = 1;
    end
    check(done, t, {63'h0, done}, 64'h1);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    realtime t0, t1, t2;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_CFG, v);  check(v == 0, "R1 status after reset", v, 0);
    rd(A_DAT, v);  check(v == 0, "R1 data after reset", v, 0);
    check(!mdc && !dut_oe, "R1 pins idle", {mdc, dut_oe}, 0);

    // R3 control write without read bit
    wr(A_CTL, (5 << 5) | 3);
    rd(A_CTL, v);  check(v == 32'h00A3, "R3 control fields", v, 32'h00A3);
    rd(A_CFG, v);  check(!v[31], "R3 no frame from control", v[31], 0);

    // R4 short-format write, R9 busy, R11 MDC shape
    expect_frame(fr(2'b01, 2'b01, 5, 3, 2'b10, 16'hA5C3), "R4 R8 short write frame");
    wr(A_DAT, 32'h0000_A5C3);
    rd(A_CFG, v);  check(v[31], "R9 busy after launch", v[31], 1);
    @(posedge mdc); t0 = $realtime;
    @(negedge mdc); t1 = $realtime;
    @(posedge mdc); t2 = $realtime;
    check(int'((t2 - t0) / 4.0) == DIV, "R11 MDC period", int'((t2 - t0) / 4.0), DIV);
    check(int'((t1 - t0) / 4.0) == DIV / 2, "R11 MDC high half", int'((t1 - t0) / 4.0), DIV / 2);
    wait_idle("R9 busy clears");
    check(!mdc, "R11 MDC low when idle", mdc, 0);

    // R6 short-format read
    pdata = 16'h1234;
    expect_frame(fr(2'b01, 2'b10, 7, 9, 2'b10, 16'h1234), "R6 short read frame");
    wr(A_CTL, 32'h8000 | (7 << 5) | 9);
    wait_idle("R6 read completes");
    rd(A_CFG, v);  check(!v[1], "R7 no error on answered read", v[1], 0);
    rd(A_DAT, v);  check(v == 32'h1234, "R6 read data", v, 32'h1234);

    // R7 silent PHY
    pmute = 1;
    expect_frame(fr(2'b01, 2'b10, 2, 4, 2'b11, 16'hFFFF), "R7 silent read frame");
    wr(A_CTL, 32'h8000 | (2 << 5) | 4);
    wait_idle("R7 read completes");
    rd(A_CFG, v);  check(v[1], "R7 error flag set", v[1], 1);
    rd(A_DAT, v);  check(v == 32'hFFFF, "R7 data of silent read", v, 32'hFFFF);
    pmute = 0;

    // R7 clear on next frame; R5 short mode address write
    expect_frame(fr(2'b01, 2'b01, 2, 4, 2'b10, 16'h00FF), "R4 short write after error");
    wr(A_DAT, 32'h00FF);
    rd(A_CFG, v);  check(!v[1], "R7 error cleared at launch", v[1], 0);
    wait_idle("R4 write completes");
    wr(A_ADR, 32'h0777);
    rd(A_CFG, v);  check(!v[31], "R5 no frame in short mode", v[31], 0);
    rd(A_ADR, v);  check(v == 32'h0777, "R5 address stored", v, 32'h0777);

    // R2 extended framing
    wr(A_CFG, 32'h40);
    rd(A_CFG, v);  check(v[6], "R2 extended bit readback", v[6], 1);
    wr(A_CTL, (3 << 5) | 1);
    expect_frame(fr(2'b00, 2'b00, 3, 1, 2'b10, 16'h1234), "R5 address frame");
    wr(A_ADR, 32'h1234);
    wait_idle("R5 address frame completes");
    expect_frame(fr(2'b00, 2'b01, 3, 1, 2'b10, 16'hCAFE), "R4 extended write frame");
    wr(A_DAT, 32'hCAFE);
    wait_idle("R4 extended write completes");
    pdata = 16'hBEEF;
    expect_frame(fr(2'b00, 2'b11, 3, 1, 2'b10, 16'hBEEF), "R6 extended read frame");
    wr(A_CTL, 32'h8000 | (3 << 5) | 1);
    wait_idle("R6 extended read completes");
    rd(A_DAT, v);  check(v == 32'hBEEF, "R6 extended read data", v, 32'hBEEF);
    rd(A_CFG, v);  check(!v[1], "R7 extended read no error", v[1], 0);

    // R10 writes while busy are dropped
    expect_frame(fr(2'b00, 2'b01, 3, 1, 2'b10, 16'h0F0F), "R10 frame before busy writes");
    wr(A_DAT, 32'h0F0F);
    wr(A_CTL, 32'h8000 | (9 << 5) | 7);
    wr(A_DAT, 32'h1111);
    wr(A_ADR, 32'h2222);
    wait_idle("R10 frame completes");
    rd(A_CTL, v);  check(v == 32'h0061, "R10 control unchanged", v, 32'h0061);
    rd(A_ADR, v);  check(v == 32'h1234, "R10 address unchanged", v, 32'h1234);
    repeat (40) @(negedge clk);
    rd(A_CFG, v);  check(!v[31], "R10 no delayed frame", v[31], 0);

    wr(A_CFG, 32'h0);
    rd(A_CFG, v);  check(!v[6], "R2 short framing restored", v[6], 0);

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R8 all expected frames seen", exp_q.size(), 0);
    check(clash == 0, "R6 no drive overlap with PHY", clash, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule